// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic core of an accumulator-style datapath. It holds an 8-bit accumulator and an 8-bit temporary operand register. On an execute strobe it applies one of eight operations, using the accumulator as the first operand and the temporary register as the second. The result goes back into the accumulator. A packed status byte is rewritten with carry, parity, auxiliary carry, zero and sign.

The surrounding sequencer loads the two operands through dedicated load ports. It picks an operation code and pulses the execute strobe for one clock. It then reads the accumulator and the status byte, which are driven straight from registers. The compare operation updates only the status byte, so the sequencer can test operands without losing the accumulator.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, the temporary register and the status byte to 0x00 on the next rising edge.
- R2: With `acc_load` high the accumulator takes `acc_din` on the next edge. With `tmp_load` high the temporary register takes `tmp_din`. A load alone never changes the status byte.
- R3: While `exec_en` is low, `op_sel` has no effect: the accumulator (unless loaded) and the status byte keep their values.
- R4: Codes 0 (ADD) and 1 (ADC) write acc + tmp, plus the current carry flag for ADC, into the accumulator. The carry flag is set on a carry out of bit 7.
- R5: Codes 2 (SUB) and 3 (SBB) write acc - tmp, minus the current carry flag for SBB. The carry flag is set when a borrow out of bit 7 occurs.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) write the bitwise result and clear both the carry and auxiliary carry flags.
- R7: Code 7 (CMP) sets the flags exactly as SUB would, but leaves the accumulator unchanged.
- R8: Status bit 6 (zero) is set when the 8-bit result is 0x00. Status bit 7 (sign) copies bit 7 of the result.
- R9: Status bit 2 (parity) is set when the result has an even number of 1 bits.
- R10: Status bit 4 (auxiliary carry) is set on a carry out of bit 3 for additions, and on a borrow from bit 4 into bit 3 for SUB, SBB and CMP.
- R11: Status bits 5, 3 and 1 always read as 0. Carry sits at bit 0.
- R12: When `acc_load` and `exec_en` are high in the same cycle, the accumulator takes `acc_din`, while the status byte still takes the flags of the executed operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code, 0..7 = ADD, ADC, SUB, SBB, AND, OR, XOR, CMP |
| exec_en | input | 1 | Execute strobe; the operation takes effect on this edge |
| acc_load | input | 1 | Load strobe for the accumulator |
| acc_din | input | DATA_W (8) | Accumulator load value |
| tmp_load | input | 1 | Load strobe for the temporary operand register |
| tmp_din | input | DATA_W (8) | Temporary register load value |
| acc_q | output | DATA_W (8) | Registered accumulator |
| flags_q | output | 8 | Registered status byte |

## Verification
The bench builds the block with its defaults: `DATA_W` = 8 and `NIB_W` = 4. With these values the nibble boundary sits at bit 3, so the auxiliary carry and borrow cases around 0x0F/0x10 can be reached. Carry out of bit 7 and borrow below 0x00 are reached directly, and every parity and sign pattern of a byte is available. Each table vector first sets or clears the carry flag through a real operation. This lets ADC and SBB be seen with both carry-in values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam int FLAG_W     = 8;
  localparam int FL_CARRY   = 0;
  localparam int FL_PARITY  = 2;
  localparam int FL_AUX     = 4;
  localparam int FL_ZERO    = 6;
  localparam int FL_SIGN    = 7;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              aux
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [DATA_W-1:0] b_eff;
  logic              c_in_eff;
  logic [NIB_W:0]    lo_sum;
  logic [HI_W:0]     hi_sum;

  always_comb begin
    b_eff    = sub ? ~b : b;
    c_in_eff = sub ? ~cin : cin;
    lo_sum   = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, c_in_eff};
    hi_sum   = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b_eff[DATA_W-1:NIB_W]}
             + {{HI_W{1'b0}}, lo_sum[NIB_W]};
    res      = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
    carry    = sub ? ~hi_sum[HI_W] : hi_sum[HI_W];
    aux      = sub ? ~lo_sum[NIB_W] : lo_sum[NIB_W];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      default: res = a ^ b;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              aux,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags            = '0;
    flags[FL_CARRY]  = carry;
    flags[FL_PARITY] = ~(^res);
    flags[FL_AUX]    = aux;
    flags[FL_ZERO]   = (res == '0);
    flags[FL_SIGN]   = res[DATA_W-1];
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic              exec_en,
  input  logic              acc_load,
  input  logic [DATA_W-1:0] acc_din,
  input  logic              tmp_load,
  input  logic [DATA_W-1:0] tmp_din,
  output logic [DATA_W-1:0] acc_q,
  output logic [7:0]        flags_q
);
  alu_op_e           op;
  logic [DATA_W-1:0] tmp_q;
  logic              is_sub, is_logic, use_cin, writes_acc;
  logic [DATA_W-1:0] arith_res, logic_res, alu_res;
  logic              arith_c, arith_ac, res_c, res_ac;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    op         = alu_op_e'(op_sel);
    is_sub     = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    use_cin    = (op == OP_ADC) || (op == OP_SBB);
    is_logic   = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    writes_acc = (op != OP_CMP);
  end

  acc_alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .a     (acc_q),
    .b     (tmp_q),
    .sub   (is_sub),
    .cin   (use_cin & flags_q[FL_CARRY]),
    .res   (arith_res),
    .carry (arith_c),
    .aux   (arith_ac)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op  (op),
    .a   (acc_q),
    .b   (tmp_q),
    .res (logic_res)
  );

  always_comb begin
    alu_res = is_logic ? logic_res : arith_res;
    res_c   = is_logic ? 1'b0 : arith_c;
    res_ac  = is_logic ? 1'b0 : arith_ac;
  end

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .res   (alu_res),
    .carry (res_c),
    .aux   (res_ac),
    .flags (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      tmp_q   <= '0;
      flags_q <= '0;
    end else begin
      if (acc_load)
        acc_q <= acc_din;
      else if (exec_en && writes_acc)
        acc_q <= alu_res;
      if (tmp_load)
        tmp_q <= tmp_din;
      if (exec_en)
        flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_sel,
  input logic              exec_en,
  input logic              acc_load,
  input logic [DATA_W-1:0] acc_din,
  input logic [DATA_W-1:0] acc_q,
  input logic [7:0]        flags_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (flags_q == '0));

  p_acc_load_r2: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> acc_q == $past(acc_din));

  p_hold_acc_r3: assert property (@(posedge clk) disable iff (rst)
    (!exec_en && !acc_load) |=> $stable(acc_q));

  p_hold_flags_r3: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(flags_q));

  p_logic_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op_sel inside {3'd4, 3'd5, 3'd6})) |=> (flags_q[0] == 1'b0) && (flags_q[4] == 1'b0));

  p_cmp_keeps_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !acc_load && op_sel == 3'd7) |=> $stable(acc_q));

  p_zero_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !acc_load && op_sel != 3'd7) |=> (flags_q[6] == (acc_q == '0)) && (flags_q[7] == acc_q[DATA_W-1]));

  p_parity_r9: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !acc_load && op_sel != 3'd7) |=> flags_q[2] == ~(^acc_q));

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (flags_q[5] | flags_q[3] | flags_q[1]) == 1'b0);
endmodule

bind acc_alu_core acc_alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_sel   (op_sel),
  .exec_en  (exec_en),
  .acc_load (acc_load),
  .acc_din  (acc_din),
  .acc_q    (acc_q),
  .flags_q  (flags_q)
);

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // each vector: {op[2:0], a[7:0], b[7:0], carry_in}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd0, 8'h12, 8'h34, 1'b0}, {3'd0, 8'h80, 8'h80, 1'b0},
    {3'd0, 8'h08, 8'h08, 1'b0}, {3'd1, 8'h0F, 8'h00, 1'b1},
    {3'd1, 8'hFE, 8'h01, 1'b1}, {3'd1, 8'h11, 8'h22, 1'b0},
    {3'd2, 8'h50, 8'h20, 1'b0}, {3'd2, 8'h10, 8'h01, 1'b0},
    {3'd2, 8'h05, 8'h07, 1'b0}, {3'd3, 8'h05, 8'h05, 1'b1},
    {3'd3, 8'h40, 8'h01, 1'b0}, {3'd4, 8'hAA, 8'h0F, 1'b1},
    {3'd5, 8'hA0, 8'h05, 1'b1}, {3'd6, 8'hFF, 8'hFF, 1'b1},
    {3'd6, 8'h3C, 8'h01, 1'b0}, {3'd7, 8'h20, 8'h30, 1'b0},
    {3'd7, 8'h30, 8'h30, 1'b1}, {3'd7, 8'h31, 8'h02, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op_sel;
  logic       exec_en, acc_load, tmp_load;
  logic [7:0] acc_din, tmp_din;
  logic [7:0] acc_q, flags_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .exec_en(exec_en),
    .acc_load(acc_load), .acc_din(acc_din), .tmp_load(tmp_load),
    .tmp_din(tmp_din), .acc_q(acc_q), .flags_q(flags_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    exec_en = 0; acc_load = 0; tmp_load = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic load_both(input logic [7:0] a, input logic [7:0] b);
    acc_load = 1; acc_din = a; tmp_load = 1; tmp_din = b;
    cyc();
  endtask

  task automatic exec_op(input logic [2:0] op);
    op_sel = op; exec_en = 1;
    cyc();
  endtask

  // sets (via ADD FF+01) or clears (via AND) the carry flag
  task automatic prime_carry(input logic c);
    if (c) begin
      load_both(8'hFF, 8'h01);
      exec_op(3'd0);
    end else begin
      exec_op(3'd4);
    end
  endtask

  // independent model from the requirements, using integer arithmetic
  function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci);
    int r, lo;
    logic [7:0] res, fl;
    logic cy, ac;
    int c = (op == 3'd1 || op == 3'd3) ? int'(ci) : 0;
    cy = 0; ac = 0;
    case (op)
      3'd0, 3'd1: begin
        r = int'(a) + int'(b) + c;  lo = int'(a % 16) + int'(b % 16) + c;
        cy = (r > 255); ac = (lo > 15);
      end
      3'd2, 3'd3, 3'd7: begin
        r = int'(a) - int'(b) - c;  lo = int'(a % 16) - int'(b % 16) - c;
        cy = (r < 0); ac = (lo < 0);
      end
      3'd4: r = int'(a & b);
      3'd5: r = int'(a | b);
      default: r = int'(a ^ b);
    endcase
    res = 8'(r & 255);
    fl = 8'h00;
    fl[0] = cy; fl[4] = ac; fl[6] = (res == 8'h00); fl[7] = res[7];
    fl[2] = ($countones(res) % 2 == 0);
    return {(op == 3'd7) ? a : res, fl};
  endfunction

  initial begin
    rst = 1; idle(); op_sel = 0; acc_din = 0; tmp_din = 0;
    acc_din = 8'h5A; tmp_din = 8'hA5;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 acc after reset", acc_q, 8'h00);
    check("R1 flags after reset", flags_q, 8'h00);
    rst = 0;
    @(negedge clk);

    // table walk: R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [7:0] a, b;
      logic ci;
      logic [15:0] exp;
      {op, a, b, ci} = VEC[i];
      prime_carry(ci);
      load_both(a, b);
      exec_op(op);
      exp = model(op, a, b, ci);
      check($sformatf("R4/R5/R6/R7 vec %0d acc", i), acc_q, exp[15:8]);
      check($sformatf("R8/R9/R10/R11 vec %0d flags", i), flags_q, exp[7:0]);
    end

    // R10: nibble carry alone, 0F+01 -> 10, flags 10
    prime_carry(1'b0);
    load_both(8'h0F, 8'h01); exec_op(3'd0);
    check("R10 aux carry acc", acc_q, 8'h10);
    check("R10 aux carry flags", flags_q, 8'h10);
    // R4 wrap to zero: FF+01 -> 00, flags 55
    load_both(8'hFF, 8'h01); exec_op(3'd0);
    check("R4 wrap acc", acc_q, 8'h00);
    check("R8 wrap flags", flags_q, 8'h55);
    // R5 borrow: 00-01 -> FF, flags 95
    load_both(8'h00, 8'h01); exec_op(3'd2);
    check("R5 borrow acc", acc_q, 8'hFF);
    check("R5 borrow flags", flags_q, 8'h95);
    // R7: equal compare, acc kept 42, flags 44
    load_both(8'h42, 8'h42); exec_op(3'd7);
    check("R7 cmp acc kept", acc_q, 8'h42);
    check("R7 cmp flags", flags_q, 8'h44);

    // R2: tmp load alone leaves acc and flags
    tmp_load = 1; tmp_din = 8'h01; cyc();
    check("R2 tmp load acc", acc_q, 8'h42);
    check("R2 tmp load flags", flags_q, 8'h44);
    // and the new tmp value is used: 42+01=43, flags 00 (odd parity)
    exec_op(3'd0);
    check("R2 tmp used acc", acc_q, 8'h43);
    check("R2 tmp used flags", flags_q, 8'h00);
    // R2: acc load alone leaves flags
    acc_load = 1; acc_din = 8'h9C; cyc();
    check("R2 acc load acc", acc_q, 8'h9C);
    check("R2 acc load flags", flags_q, 8'h00);

    // R3: op_sel without exec_en has no effect
    op_sel = 3'd6; cyc();
    op_sel = 3'd2; cyc();
    check("R3 hold acc", acc_q, 8'h9C);
    check("R3 hold flags", flags_q, 8'h00);

    // R12: load and execute together: tmp=20, acc=10, ADD -> flags of 30 = 04, acc=77
    load_both(8'h10, 8'h20);
    op_sel = 3'd0; exec_en = 1; acc_load = 1; acc_din = 8'h77; cyc();
    check("R12 acc takes load", acc_q, 8'h77);
    check("R12 flags from op", flags_q, 8'h04);

    // R1: reset mid-run clears
    rst = 1; cyc(); rst = 0;
    check("R1 acc after late reset", acc_q, 8'h00);
    check("R1 flags after late reset", flags_q, 8'h00);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule